// File: doc/BRIEF.md
# Per-Bit Access-Policy Register Bank

This block is a small bank of 32-bit control and status registers behind a simple memory-mapped request port. Each register has its own five per-bit attribute masks and its own reset word. The masks mark bits as read-only, write-one-to-clear, reserved, clear-on-read or unimplemented. Every access carries a size code that selects the active low-order byte lanes. The bank merges software writes under these policies, applies the side effects of reads, and lets hardware status inputs set write-one-to-clear bits.

A request is accepted on any cycle where `req_valid` is high. One cycle later a response state machine presents the result. It has five states. `RSP_IDLE` means no request was seen. `RSP_READ` and `RSP_WRITE` follow a read or a write to a mapped register. `RSP_MISS_RD` and `RSP_MISS_WR` follow an access to an unmapped address. The next state depends only on the request of the current cycle. From any state, no request goes to `RSP_IDLE`. A mapped read goes to `RSP_READ` and a mapped write to `RSP_WRITE`. An unmapped read goes to `RSP_MISS_RD` and an unmapped write to `RSP_MISS_WR`. Requests can therefore follow each other on every cycle. Register slots are configured through the `PRESENT` parameter, and the mask words are parameter arrays indexed by slot.

Top module: `regbank_policy`

## Requirements
- R1: After reset, slot 0 holds 0x00001234, slot 1 holds 0x00000000 and slot 2 holds 0xABCD0F0F. `rsp_valid` and all error flags are low.
- R2: The slot index is `req_addr` shifted right by 2. An address is mapped only when bits 1:0 are zero, the index is below `NUM_REGS` and the slot's `PRESENT` bit is 1; by default slots 0 to 2 are present and slot 3 is a hole. An unmapped write changes no register. An unmapped read returns 0. Both pulse `err_unmapped` and raise neither `err_reserved` nor `err_unimp`.
- R3: `req_size` 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. The active lanes are the low min(size,4) bytes, so size 0 gives mask 0x000000FF, size 1 gives 0x0000FFFF, and sizes 2 and 3 give 0xFFFFFFFF.
- R4: On a mapped write, a bit takes the written data unless the bit is read-only, write-one-to-clear, reserved or outside the active lanes; such a bit keeps its value. By default slot 2 bits 31:16 are read-only.
- R5: After that merge, every write-one-to-clear bit whose written data bit is 1 is cleared, whether or not it lies in the active lanes. By default the write-one-to-clear bits are slot 1 bits 7:0.
- R6: `rsp_valid` is high exactly in the cycle after each accepted request. After a mapped read, `rsp_rdata` is the stored value from before the read ANDed with the lane mask. In all other response cycles it is 0.
- R7: A mapped read clears every clear-on-read bit inside its active lanes. By default these are slot 2 bits 15:8.
- R8: `err_reserved` pulses in the cycle after a mapped write whose data differs from the stored value in any reserved bit; the reserved bits stay unchanged. By default the reserved bits are slot 0 bits 31:24.
- R9: `err_unimp` pulses in the cycle after a mapped write whose data has a 1 in any unimplemented bit. By default these are slot 0 bits 23:20. The bits are still stored as ordinary bits.
- R10: A 1 on `hw_set` sets the matching bit only if that bit is write-one-to-clear. When it arrives in the same cycle as a software clear, the set wins. `hw_set` has no effect on other bits.
- R11: Each error flag is high for one cycle per offending request and is never high in a cycle that did not follow a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code (R3) |
| req_wdata | input | 32 | Write data |
| hw_set | input | NUM_REGS x 32 | Per-slot hardware set pulses |
| rsp_valid | output | 1 | Response cycle for the previous request |
| rsp_rdata | output | 32 | Read data |
| err_unmapped | output | 1 | Previous access hit no register |
| err_reserved | output | 1 | Previous write tried to change reserved bits |
| err_unimp | output | 1 | Previous write set unimplemented bits |

## Verification
The hardest case to reach is a hardware set pulse landing in the same cycle as a software write-one-to-clear of the same bit. It only occurs when the bench drives `hw_set` and a write request on the same clock edge. The stimulus builds this cycle on purpose and then reads the slot back. Clear-on-read bits that lie outside the active lanes must survive a narrow read, so the bench reads a slot first at size 0 and then at full width. Every cycle is compared against a behavioural model that tracks the register contents and the expected response.

// File: rtl/rb_pkg.sv
package rb_pkg;

    typedef logic [31:0] word_t;

    typedef enum logic [2:0] {
        RSP_IDLE,
        RSP_READ,
        RSP_WRITE,
        RSP_MISS_RD,
        RSP_MISS_WR
    } rsp_state_e;

    // Byte lanes enabled by an access: low min(2**size, 4) bytes.
    function automatic word_t lane_mask(input logic [1:0] size);
        word_t m;
        unique case (size)
            2'd0:    m = 32'h0000_00FF;
            2'd1:    m = 32'h0000_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rb_decode.sv
module rb_decode #(
    parameter int unsigned           NUM_REGS = 4,
    parameter int unsigned           ADDR_W   = 8,
    parameter logic [NUM_REGS-1:0]   PRESENT  = '1,
    localparam int unsigned          IDX_W    = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);

    logic present_bit;

    assign idx = addr[ADDR_W-1:2];

    always_comb begin
        present_bit = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) begin
                present_bit = PRESENT[i];
            end
        end
    end

    assign hit = (addr[1:0] == 2'b00) && present_bit;

endmodule

// File: rtl/rb_cell.sv
module rb_cell
    import rb_pkg::*;
#(
    parameter word_t RO_BITS    = '0,
    parameter word_t W1C_BITS   = '0,
    parameter word_t RSVD_BITS  = '0,
    parameter word_t COR_BITS   = '0,
    parameter word_t RESET_WORD = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  logic  rd_en,
    input  word_t wdata,
    input  word_t lanes,
    input  word_t hw_set,
    output word_t q
);

    word_t keep_mask;
    word_t nxt;

    assign keep_mask = RO_BITS | W1C_BITS | RSVD_BITS | ~lanes;

    always_comb begin
        nxt = q;
        if (wr_en) begin
            nxt = (wdata & ~keep_mask) | (q & keep_mask);
            nxt = nxt & ~(wdata & W1C_BITS);
        end else if (rd_en) begin
            nxt = q & ~(COR_BITS & lanes);
        end
        // hardware set applied last: wins over a software clear
        nxt = nxt | (hw_set & W1C_BITS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RESET_WORD;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/rb_rsp_fsm.sv
module rb_rsp_fsm
    import rb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req_valid,
    input  logic  req_write,
    input  logic  hit,
    input  word_t rd_word,
    input  logic  rsvd_change,
    input  logic  unimp_set,
    output logic  rsp_valid,
    output word_t rsp_rdata,
    output logic  err_unmapped,
    output logic  err_reserved,
    output logic  err_unimp
);

    rsp_state_e state, state_nxt;
    word_t      rdata_q;
    logic       rsvd_q, unimp_q;
    logic       wr_hit;

    assign wr_hit = req_valid && req_write && hit;

    always_comb begin
        if (!req_valid) begin
            state_nxt = RSP_IDLE;
        end else if (!hit) begin
            state_nxt = req_write ? RSP_MISS_WR : RSP_MISS_RD;
        end else begin
            state_nxt = req_write ? RSP_WRITE : RSP_READ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= RSP_IDLE;
            rdata_q <= '0;
            rsvd_q  <= 1'b0;
            unimp_q <= 1'b0;
        end else begin
            state   <= state_nxt;
            rdata_q <= (state_nxt == RSP_READ) ? rd_word : '0;
            rsvd_q  <= wr_hit && rsvd_change;
            unimp_q <= wr_hit && unimp_set;
        end
    end

    always_comb begin
        rsp_valid    = 1'b0;
        err_unmapped = 1'b0;
        unique case (state)
            RSP_IDLE: begin
            end
            RSP_READ, RSP_WRITE: begin
                rsp_valid = 1'b1;
            end
            RSP_MISS_RD, RSP_MISS_WR: begin
                rsp_valid    = 1'b1;
                err_unmapped = 1'b1;
            end
            default: begin
            end
        endcase
        rsp_rdata    = rdata_q;
        err_reserved = rsvd_q;
        err_unimp    = unimp_q;
    end

endmodule

// File: rtl/regbank_policy.sv
module regbank_policy
    import rb_pkg::*;
#(
    parameter int unsigned                NUM_REGS   = 4,
    parameter int unsigned                ADDR_W     = 8,
    parameter logic [NUM_REGS-1:0]        PRESENT    = 4'b0111,
    parameter logic [NUM_REGS-1:0][31:0]  RO_MASK    = {32'h0, 32'hFFFF_0000, 32'h0, 32'h0},
    parameter logic [NUM_REGS-1:0][31:0]  W1C_MASK   = {32'h0, 32'h0, 32'h0000_00FF, 32'h0},
    parameter logic [NUM_REGS-1:0][31:0]  RSVD_MASK  = {32'h0, 32'h0, 32'h0, 32'hFF00_0000},
    parameter logic [NUM_REGS-1:0][31:0]  COR_MASK   = {32'h0, 32'h0000_FF00, 32'h0, 32'h0},
    parameter logic [NUM_REGS-1:0][31:0]  UNIMP_MASK = {32'h0, 32'h0, 32'h0, 32'h00F0_0000},
    parameter logic [NUM_REGS-1:0][31:0]  RESET_VAL  = {32'h0, 32'hABCD_0F0F, 32'h0, 32'h0000_1234}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [1:0]                 req_size,
    input  logic [31:0]                req_wdata,
    input  logic [NUM_REGS-1:0][31:0]  hw_set,
    output logic                       rsp_valid,
    output logic [31:0]                rsp_rdata,
    output logic                       err_unmapped,
    output logic                       err_reserved,
    output logic                       err_unimp
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic                      hit;
    logic [IDX_W-1:0]          idx;
    word_t                     lanes;
    logic [NUM_REGS-1:0][31:0] store;
    word_t                     sel_q, sel_rsvd, sel_unimp;

    assign lanes = lane_mask(req_size);

    rb_decode #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W),
        .PRESENT  (PRESENT)
    ) u_decode (
        .addr (req_addr),
        .hit  (hit),
        .idx  (idx)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        if (PRESENT[g]) begin : g_cell
            logic sel;
            assign sel = req_valid && hit && (idx == IDX_W'(g));
            rb_cell #(
                .RO_BITS    (RO_MASK[g]),
                .W1C_BITS   (W1C_MASK[g]),
                .RSVD_BITS  (RSVD_MASK[g]),
                .COR_BITS   (COR_MASK[g]),
                .RESET_WORD (RESET_VAL[g])
            ) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (sel && req_write),
                .rd_en  (sel && !req_write),
                .wdata  (req_wdata),
                .lanes  (lanes),
                .hw_set (hw_set[g]),
                .q      (store[g])
            );
        end else begin : g_hole
            assign store[g] = '0;
        end
    end

    always_comb begin
        sel_q     = '0;
        sel_rsvd  = '0;
        sel_unimp = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) begin
                sel_q     = store[i];
                sel_rsvd  = RSVD_MASK[i];
                sel_unimp = UNIMP_MASK[i];
            end
        end
    end

    rb_rsp_fsm u_rsp (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .hit          (hit),
        .rd_word      (sel_q & lanes),
        .rsvd_change  (|((sel_q ^ req_wdata) & sel_rsvd)),
        .unimp_set    (|(req_wdata & sel_unimp)),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .err_unmapped (err_unmapped),
        .err_reserved (err_reserved),
        .err_unimp    (err_unimp)
    );

endmodule

// File: rtl/rb_bank_checker.sv
module rb_bank_checker #(
    parameter int unsigned               NUM_REGS = 4,
    parameter logic [NUM_REGS-1:0][31:0] W1C_MASK = '0
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_write,
    input logic [NUM_REGS-1:0][31:0] hw_set,
    input logic [NUM_REGS-1:0][31:0] store,
    input logic                      rsp_valid,
    input logic [31:0]               rsp_rdata,
    input logic                      err_unmapped,
    input logic                      err_reserved,
    input logic                      err_unimp
);

    a_r6_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r6_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r2_miss_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (err_unmapped && $past(!req_write)) |-> (rsp_rdata == 32'h0));

    a_r8_rsvd_only_mapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        err_reserved |-> ($past(req_valid && req_write) && !err_unmapped));

    a_r9_unimp_only_mapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        err_unimp |-> ($past(req_valid && req_write) && !err_unmapped));

    a_r11_flags_need_req: assert property (@(posedge clk) disable iff (!rst_n)
        (err_unmapped || err_reserved || err_unimp) |-> rsp_valid);

    a_r10_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hw_set & W1C_MASK)) |=>
            ((store & $past(hw_set & W1C_MASK)) == $past(hw_set & W1C_MASK)));

endmodule

bind regbank_policy rb_bank_checker #(
    .NUM_REGS (NUM_REGS),
    .W1C_MASK (W1C_MASK)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .hw_set       (hw_set),
    .store        (store),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .err_unmapped (err_unmapped),
    .err_reserved (err_reserved),
    .err_unimp    (err_unimp)
);

// File: tb/regbank_policy_test.sv
module regbank_policy_test;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [7:0]       req_addr = '0;
    logic [1:0]       req_size = '0;
    logic [31:0]      req_wdata = '0;
    logic [3:0][31:0] hw_set = '0;
    logic             rsp_valid;
    logic [31:0]      rsp_rdata;
    logic             err_unmapped, err_reserved, err_unimp;

    int checks = 0;
    int errors = 0;
    bit run = 0;
    bit done = 0;

    always #4 clk = ~clk;

    regbank_policy uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .hw_set(hw_set), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .err_unmapped(err_unmapped), .err_reserved(err_reserved),
        .err_unimp(err_unimp)
    );

    // Policy masks taken from the requirements
    logic [31:0] ro   [3] = '{32'h0, 32'h0, 32'hFFFF_0000};
    logic [31:0] w1c  [3] = '{32'h0, 32'h0000_00FF, 32'h0};
    logic [31:0] rsv  [3] = '{32'hFF00_0000, 32'h0, 32'h0};
    logic [31:0] cor  [3] = '{32'h0, 32'h0, 32'h0000_FF00};
    logic [31:0] uni  [3] = '{32'h00F0_0000, 32'h0, 32'h0};
    logic [31:0] rstv [3] = '{32'h0000_1234, 32'h0, 32'hABCD_0F0F};

    logic [31:0] m [3];
    logic        e_v, e_u, e_rs, e_ui;
    logic [31:0] e_rd;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < 3; r++) m[r] = rstv[r];
            e_v = 0; e_u = 0; e_rs = 0; e_ui = 0; e_rd = 0;
        end else begin
            logic [31:0] lane;
            int          ix;
            bit          hit;
            lane = (req_size == 0) ? 32'hFF : (req_size == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
            ix   = int'(req_addr) / 4;
            hit  = (req_addr % 4 == 0) && (ix < 3);
            e_v  = req_valid;
            e_u  = req_valid && !hit;
            e_rs = 0; e_ui = 0; e_rd = 0;
            if (req_valid && hit) begin
                if (req_write) begin
                    e_rs = ((m[ix] ^ req_wdata) & rsv[ix]) != 0;
                    e_ui = (req_wdata & uni[ix]) != 0;
                    for (int b = 0; b < 32; b++) begin
                        if (!(ro[ix][b] || w1c[ix][b] || rsv[ix][b] || !lane[b]))
                            m[ix][b] = req_wdata[b];
                        if (req_wdata[b] && w1c[ix][b]) m[ix][b] = 1'b0;
                    end
                end else begin
                    e_rd  = m[ix] & lane;
                    m[ix] = m[ix] & ~(cor[ix] & lane);
                end
            end
            for (int r = 0; r < 3; r++) m[r] = m[r] | (hw_set[r] & w1c[r]);
        end
    end

    // Cycle compare against the model
    always @(negedge clk) begin
        if (run && rst_n) begin
            chk("R6 rsp_valid", {31'b0, rsp_valid}, {31'b0, e_v});
            chk("R6 rsp_rdata", rsp_rdata, e_rd);
            chk("R2 err_unmapped", {31'b0, err_unmapped}, {31'b0, e_u});
            chk("R8 err_reserved", {31'b0, err_reserved}, {31'b0, e_rs});
            chk("R9 err_unimp", {31'b0, err_unimp}, {31'b0, e_ui});
        end
    end

    logic f_un, f_rs, f_ui;
    logic [31:0] rd;

    task automatic access(input bit wr, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        f_un = err_unmapped; f_rs = err_reserved; f_ui = err_unimp; rd = rsp_rdata;
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run = 1'b1;
        @(negedge clk);
        chk("R1 rsp_valid idle", {31'b0, rsp_valid}, 32'h0);
        chk("R1 flags idle", {29'b0, err_unmapped, err_reserved, err_unimp}, 32'h0);
        access(0, 8'h00, 2, 0); chk("R1 slot0 reset", rd, 32'h0000_1234);
        access(0, 8'h04, 2, 0); chk("R1 slot1 reset", rd, 32'h0);
        access(0, 8'h08, 2, 0); chk("R1 slot2 reset", rd, 32'hABCD_0F0F);

        // R4 plain merge
        access(1, 8'h00, 2, 32'h000B_5678);
        chk("R8 no change no flag", {31'b0, f_rs}, 32'h0);
        access(0, 8'h00, 2, 0); chk("R4 merge", rd, 32'h000B_5678);

        // R3 narrow write, reserved and unimplemented flags
        access(1, 8'h00, 0, 32'hFFFF_FF11);
        chk("R8 reserved flag", {31'b0, f_rs}, 32'h1);
        chk("R9 unimp flag", {31'b0, f_ui}, 32'h1);
        @(negedge clk);
        chk("R11 flag single pulse", {30'b0, err_reserved, err_unimp}, 32'h0);
        access(0, 8'h00, 2, 0); chk("R3 byte lane write", rd, 32'h000B_5611);
        access(0, 8'h00, 0, 0); chk("R3 size0 read", rd, 32'h0000_0011);
        access(0, 8'h00, 1, 0); chk("R3 size1 read", rd, 32'h0000_5611);
        access(0, 8'h00, 3, 0); chk("R3 size3 read", rd, 32'h000B_5611);

        // R8 reserved bits stay
        access(1, 8'h00, 2, 32'h0100_0000);
        chk("R8 flag on change", {31'b0, f_rs}, 32'h1);
        access(0, 8'h00, 2, 0); chk("R8 reserved kept", rd, 32'h0);

        // R9 unimplemented bits still stored
        access(1, 8'h00, 2, 32'h0010_0000);
        chk("R9 unimp flag", {30'b0, f_ui, f_rs}, 32'h2);
        access(0, 8'h00, 2, 0); chk("R9 stored", rd, 32'h0010_0000);

        // R10 hardware set, R5 write-one-to-clear
        @(negedge clk); hw_set[1] = 32'h0000_FFA5;
        @(negedge clk); hw_set = '0;
        access(0, 8'h04, 2, 0); chk("R10 hw set w1c only", rd, 32'h0000_00A5);
        access(1, 8'h04, 0, 32'h0000_0081);
        access(0, 8'h04, 2, 0); chk("R5 w1c clear", rd, 32'h0000_0024);
        access(1, 8'h04, 2, 32'h1234_0004);
        access(0, 8'h04, 2, 0); chk("R5 w1c with rw merge", rd, 32'h1234_0020);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h04; req_size = 0;
        req_wdata = 32'h20; hw_set[1] = 32'h20;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_wdata = '0; hw_set = '0;
        access(0, 8'h04, 2, 0); chk("R10 set wins over clear", rd, 32'h1234_0020);

        // R7 clear on read, R4 read-only
        access(1, 8'h08, 2, 32'h0000_FF00);
        access(0, 8'h08, 0, 0); chk("R7 narrow read", rd, 32'h0);
        access(0, 8'h08, 2, 0); chk("R7 cor outside lane kept", rd, 32'hABCD_FF00);
        access(0, 8'h08, 2, 0); chk("R7 cor cleared", rd, 32'hABCD_0000);
        access(1, 8'h08, 2, 32'hFFFF_FFFF);
        access(0, 8'h08, 2, 0); chk("R4 read-only kept", rd, 32'hABCD_FFFF);

        // R2 unmapped accesses
        access(1, 8'h0C, 2, 32'hFFFF_FFFF);
        chk("R2 hole write flag", {31'b0, f_un}, 32'h1);
        access(0, 8'h0C, 2, 0);
        chk("R2 hole read flag", {31'b0, f_un}, 32'h1);
        chk("R2 hole read zero", rd, 32'h0);
        access(1, 8'h02, 2, 32'hFFFF_FFFF);
        chk("R2 unaligned flag", {31'b0, f_un}, 32'h1);
        access(0, 8'h00, 2, 0); chk("R2 unaligned ignored", rd, 32'h0010_0000);
        access(0, 8'h40, 2, 0);
        chk("R2 out of range", {rd[30:0], f_un}, 32'h1);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule